// File: doc/BRIEF.md
# I2C Serial EEPROM Slave

This block is an I2C target that gives a host access to an 8192-byte array (13-bit byte address) held in on-chip storage. It runs on a fast system clock. It oversamples the two bus lines, removes short glitches from each, and finds START and STOP conditions and SCL edges. SDA is modelled as an open-drain pull-down enable: when `sda_oe` is high, the pad pulls the line low.

A write transaction carries the device address, then two byte-address bytes with the high byte first, then up to 32 data bytes. The data bytes go into a one-page staging buffer. They reach the array only after the closing STOP, during a timed internal write window. While that window is open, the block refuses its own device address. Reads can be random (a dummy address write followed by a repeated START), current-address, or sequential. A strap input chooses between two device addresses. A write-protect input blocks every array update and leaves reads alone.

Top module: `eep_slave`

## Requirements
- R1: After reset `sda_oe` is low, and it stays low whenever the block is idle (no transaction addressed to it is in progress).
- R2: The 7-bit device address is 0x50 when `addr_sel` is low and 0x54 when it is high. It is followed by the R/W bit (1 = read). A matching address is acknowledged by holding `sda_oe` high through the ninth SCL clock. Any other address gets no acknowledge.
- R3: After a write-direction device address, the block takes a high address byte and then a low address byte. Bits 7..5 of the high byte are ignored. Each following data byte is acknowledged and stored at the next address, and up to 32 data bytes fit in one transaction.
- R4: During a write, only the low 5 address bits advance. They wrap from 31 back to 0 inside the same 32-byte page, and address bits 12..5 do not change.
- R5: Staged data bytes are committed to the array only after STOP. For `WR_CYCLES` clock cycles after that STOP, the device address gets no acknowledge. Afterwards it is acknowledged and the new data reads back. A write that carried no data bytes opens no such window.
- R6: A random read (an address-only write, then a repeated START and a read-direction device address) returns the byte at the given address first.
- R7: A read that starts with no address phase (current-address read) begins at the address that follows the last byte read or written.
- R8: Sequential reads advance through the whole array and wrap from 0x1FFF to 0x0000.
- R9: When the host answers a read byte with NACK, the block releases SDA and drives no further data bits.
- R10: While `wp` is high, data bytes are still acknowledged, but the array does not change and no write window opens. Reads return correct data whatever the level of `wp`.
- R11: A pulse on SCL or SDA that lasts fewer than `FILT_CYC` clock cycles (100 ns at 50 MHz) has no effect on the bus protocol.
- R12: SDA input is sampled on the rising edge of SCL. `sda_oe` changes only while SCL is low, so every bit the block drives stays stable through the SCL high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired value) |
| addr_sel | input | 1 | Strap: low selects device address 0x50, high selects 0x54 |
| wp | input | 1 | Write protect, high blocks array updates (treat undriven as low) |
| sda_oe | output | 1 | Open-drain pull-down enable for SDA (1 = drive low) |

## Verification
The bench writes to the last two bytes and the first bytes of the array and then reads across the 0x1FFF boundary. A design that wrapped reads at the page boundary, or did not wrap at all, returns the wrong bytes there. A four-byte write that starts two bytes before a page end checks that the write pointer folds back into the same page, where a design carrying into bit 5 would write into the next page. Probing the device address straight after a write STOP, and again after a write with only an address phase, separates a correct busy window from one that is missing or opened for every STOP. Glitches shorter than the filter window are injected on both lines during an address byte: on SCL they would add bits, and on SDA while SCL is high they would look like START/STOP pairs, so the following read would fail if they got through.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam int ADDR_W = 13;
    localparam int PAGE_W = 5;
    localparam int HI_W   = ADDR_W - 8;

    localparam logic [6:0] DEV_ID_LO = 7'h50;
    localparam logic [6:0] DEV_ID_HI = 7'h54;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } link_st_e;

    typedef enum logic [1:0] {
        PH_DEV,
        PH_AHI,
        PH_ALO,
        PH_DATA
    } phase_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    function automatic logic [6:0] dev_id(input logic strap);
        return strap ? DEV_ID_HI : DEV_ID_LO;
    endfunction

    function automatic logic [ADDR_W-1:0] page_step(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:PAGE_W], a[PAGE_W-1:0] + PAGE_W'(1)};
    endfunction

endpackage

// File: rtl/eep_glitch.sv
module eep_glitch #(
    parameter int   FILT_CYC = 5,
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(FILT_CYC + 1);

    logic [1:0]    sync;
    logic [CW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync <= {2{IDLE_LVL}};
            dout <= IDLE_LVL;
            run  <= '0;
        end else begin
            sync <= {sync[0], din};
            if (sync[1] != dout) begin
                if (run == CW'(FILT_CYC - 1)) begin
                    dout <= sync[1];
                    run  <= '0;
                end else begin
                    run <= run + CW'(1);
                end
            end else begin
                run <= '0;
            end
        end
    end

    // R11: the filtered level only ever moves to the synchronised input level
    a_r11_filter_follow: assert property (@(posedge clk) disable iff (rst)
        (dout != $past(dout)) |-> (dout == $past(sync[1])));

endmodule

// File: rtl/eep_busmon.sv
module eep_busmon
    import eep_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_f,
    input  logic    sda_f,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        ev.scl_rise = !scl_q && scl_f;
        ev.scl_fall = scl_q && !scl_f;
        ev.start    = scl_q && scl_f && sda_q && !sda_f;
        ev.stop     = scl_q && scl_f && !sda_q && sda_f;
        ev.sda      = sda_f;
    end

endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int AW = 13,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/eep_slave.sv
module eep_slave
    import eep_pkg::*;
#(
    parameter int FILT_CYC  = 5,
    parameter int WR_CYCLES = 250000
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    input  logic addr_sel,
    input  logic wp,
    output logic sda_oe
);
    localparam int PAGE = 1 << PAGE_W;
    localparam int BCW  = $clog2(WR_CYCLES + 1);

    // ---------------- line conditioning ----------------
    logic [1:0] raw_lines, filt_lines;
    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_filt
        eep_glitch #(.FILT_CYC(FILT_CYC), .IDLE_LVL(1'b1)) u_filt (
            .clk  (clk),
            .rst  (rst),
            .din  (raw_lines[g]),
            .dout (filt_lines[g])
        );
    end

    logic    scl_f;
    bus_ev_t ev;
    assign scl_f = filt_lines[1];

    eep_busmon u_mon (
        .clk   (clk),
        .rst   (rst),
        .scl_f (filt_lines[1]),
        .sda_f (filt_lines[0]),
        .ev    (ev)
    );

    // ---------------- state ----------------
    link_st_e          state;
    phase_e            phase;
    logic [3:0]        bitcnt;
    logic [7:0]        shreg;
    logic [ADDR_W-1:0] addr;
    logic [HI_W-1:0]   ahi;
    logic              rd_dir;
    logic              mack_ok;
    logic              oe_q;
    logic [7:0]        pbuf [PAGE];
    logic [PAGE-1:0]   mask;
    logic              busy;
    logic [BCW-1:0]    bcnt;

    logic [7:0]        rdata;
    logic              arr_we;
    logic [PAGE_W-1:0] cofs;

    assign cofs   = bcnt[PAGE_W-1:0];
    assign arr_we = busy && (bcnt < BCW'(PAGE)) && mask[cofs];
    assign sda_oe = oe_q;

    eep_array #(.AW(ADDR_W), .DW(8)) u_arr (
        .clk   (clk),
        .we    (arr_we),
        .waddr ({addr[ADDR_W-1:PAGE_W], cofs}),
        .wdata (pbuf[cofs]),
        .raddr (addr),
        .rdata (rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            phase   <= PH_DEV;
            bitcnt  <= '0;
            shreg   <= '0;
            addr    <= '0;
            ahi     <= '0;
            rd_dir  <= 1'b0;
            mack_ok <= 1'b0;
            oe_q    <= 1'b0;
            mask    <= '0;
            busy    <= 1'b0;
            bcnt    <= '0;
            for (int i = 0; i < PAGE; i++) pbuf[i] <= '0;
        end else begin
            if (ev.start) begin
                state  <= ST_RX;
                phase  <= PH_DEV;
                bitcnt <= '0;
                oe_q   <= 1'b0;
                if (!busy) mask <= '0;
            end else if (ev.stop) begin
                state <= ST_IDLE;
                oe_q  <= 1'b0;
                if (!busy && (|mask)) begin
                    busy <= 1'b1;
                    bcnt <= '0;
                end
            end else begin
                unique case (state)
                    ST_RX: begin
                        if (ev.scl_rise && bitcnt < 4'd8) begin
                            shreg  <= {shreg[6:0], ev.sda};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (ev.scl_fall && bitcnt == 4'd8) begin
                            state <= ST_ACK;
                            oe_q  <= 1'b1;
                            unique case (phase)
                                PH_DEV: begin
                                    rd_dir <= shreg[0];
                                    if (shreg[7:1] != dev_id(addr_sel) || busy) begin
                                        state <= ST_IDLE;
                                        oe_q  <= 1'b0;
                                    end
                                end
                                PH_AHI: ahi <= shreg[HI_W-1:0];
                                PH_ALO: addr <= {ahi, shreg};
                                PH_DATA: begin
                                    if (!wp) begin
                                        pbuf[addr[PAGE_W-1:0]] <= shreg;
                                        mask[addr[PAGE_W-1:0]] <= 1'b1;
                                    end
                                    addr <= page_step(addr);
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (ev.scl_fall) begin
                            oe_q   <= 1'b0;
                            bitcnt <= '0;
                            state  <= ST_RX;
                            unique case (phase)
                                PH_DEV: begin
                                    if (rd_dir) begin
                                        state <= ST_TX;
                                        shreg <= rdata;
                                        oe_q  <= !rdata[7];
                                        addr  <= addr + ADDR_W'(1);
                                    end else begin
                                        phase <= PH_AHI;
                                    end
                                end
                                PH_AHI:  phase <= PH_ALO;
                                default: phase <= PH_DATA;
                            endcase
                        end
                    end
                    ST_TX: begin
                        if (ev.scl_fall) begin
                            if (bitcnt == 4'd7) begin
                                state <= ST_MACK;
                                oe_q  <= 1'b0;
                            end else begin
                                shreg  <= {shreg[6:0], 1'b0};
                                oe_q   <= !shreg[6];
                                bitcnt <= bitcnt + 4'd1;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (ev.scl_rise) begin
                            mack_ok <= !ev.sda;
                        end else if (ev.scl_fall) begin
                            if (mack_ok) begin
                                state  <= ST_TX;
                                shreg  <= rdata;
                                oe_q   <= !rdata[7];
                                bitcnt <= '0;
                                addr   <= addr + ADDR_W'(1);
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end

            // timed commit of the staged page
            if (busy) begin
                bcnt <= bcnt + BCW'(1);
                if (bcnt == BCW'(WR_CYCLES - 1)) begin
                    busy <= 1'b0;
                    mask <= '0;
                end
            end
        end
    end

    // R12: driven level only moves while the filtered clock is low
    a_r12_oe_scl_low: assert property (@(posedge clk) disable iff (rst)
        (oe_q != $past(oe_q)) |-> !$past(scl_f));

    // R5: no device-address acknowledge while the write window is open
    a_r5_busy_nack: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACK && phase == PH_DEV) |-> !busy);

    // R4: page bits hold steady across consecutive data-phase cycles
    a_r4_page_hold: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DATA && $past(phase) == PH_DATA)
        |-> (addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W])));

    // R1: an idle link never pulls the line
    a_r1_idle_released: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !oe_q);

endmodule

// File: tb/eep_slave_tb.sv
`timescale 1ns/1ps
module eep_slave_tb;
    localparam int Q     = 12;
    localparam int WRC   = 1000;
    localparam int FILT  = 5;
    localparam int LIMIT = 195000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic addr_sel = 1'b0;
    logic wp = 1'b0;
    wire  sda_oe;
    wire  sda_line = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    eep_slave #(.FILT_CYC(FILT), .WR_CYCLES(WRC)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .addr_sel (addr_sel),
        .wp       (wp),
        .sda_oe   (sda_oe)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int glitch_mode = 0;
    logic [7:0]  model [8192];
    bit          known [8192];
    logic [7:0]  wdat [32];
    logic [12:0] cur = '0;

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] devb(input bit rd);
        return {(addr_sel ? 7'h54 : 7'h50), rd};
    endfunction

    task automatic send_bit(input bit b);
        sda_m = b;
        if (glitch_mode == 1) begin
            wt(3); scl_m = 1'b1; wt(3); scl_m = 1'b0; wt(Q - 6);
        end else begin
            wt(Q);
        end
        scl_m = 1'b1;
        if (glitch_mode == 2 && b) begin
            wt(Q / 2); sda_m = 1'b0; wt(3); sda_m = 1'b1; wt(2 * Q - Q / 2 - 3);
        end else begin
            wt(2 * Q);
        end
        scl_m = 1'b0;
        wt(Q);
    endtask

    task automatic recv_bit(output bit v, output bit stable);
        bit v2;
        sda_m = 1'b1;
        wt(Q);
        scl_m = 1'b1;
        wt(Q);
        v = sda_line;
        wt(Q - 1);
        v2 = sda_line;
        wt(1);
        scl_m = 1'b0;
        wt(Q);
        stable = (v == v2);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        bit v, s;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        recv_bit(v, s);
        ack = !v;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        bit v, s;
        bit all_stable = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(v, s);
            b[i] = v;
            all_stable &= s;
        end
        chk("R12 data bit stable while SCL high", all_stable, 1);
        send_bit(!mack);
        if (!mack) begin
            wt(Q);
            chk("R9 SDA released after host NACK", sda_oe, 0);
        end
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; wt(Q);
        scl_m = 1'b1; wt(Q);
        sda_m = 1'b0; wt(Q);
        scl_m = 1'b0; wt(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wt(Q);
        scl_m = 1'b1; wt(Q);
        sda_m = 1'b1; wt(2 * Q);
    endtask

    task automatic send_addr(input logic [12:0] a, input string tag);
        bit ack;
        send_byte({3'($urandom), a[12:8]}, ack);
        chk({tag, " high address ack"}, ack, 1);
        send_byte(a[7:0], ack);
        chk({tag, " low address ack"}, ack, 1);
    endtask

    // R3 / R4 / R10: write n bytes from wdat starting at a
    task automatic write_txn(input logic [12:0] a, input int n, input string tag);
        bit ack;
        i2c_start();
        send_byte(devb(0), ack);
        chk("R2 write device address ack", ack, 1);
        send_addr(a, "R3");
        for (int i = 0; i < n; i++) begin
            logic [12:0] ea;
            ea = {a[12:5], 5'(a[4:0] + 5'(i))};
            send_byte(wdat[i], ack);
            chk({tag, " data ack"}, ack, 1);
            if (!wp) begin
                model[ea] = wdat[i];
                known[ea] = 1'b1;
            end
        end
        cur = {a[12:5], 5'(a[4:0] + 5'(n))};
        i2c_stop();
    endtask

    task automatic random_read(input logic [12:0] a, input int n, input string tag);
        bit ack;
        logic [7:0] b;
        i2c_start();
        send_byte(devb(0), ack);
        chk("R6 dummy write ack", ack, 1);
        send_addr(a, "R6");
        i2c_start();
        send_byte(devb(1), ack);
        chk("R6 read device address ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            logic [12:0] ea;
            ea = a + 13'(i);
            recv_byte(i < n - 1, b);
            if (known[ea]) chk(tag, b, model[ea]);
        end
        cur = a + 13'(n);
        i2c_stop();
    endtask

    task automatic probe(input bit exp_ack, input string tag);
        bit ack;
        i2c_start();
        send_byte(devb(0), ack);
        chk(tag, ack, exp_ack);
        i2c_stop();
    endtask

    initial begin
        wt(LIMIT);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit ack;
        logic [7:0] b;
        void'($urandom(32'd7731));
        for (int i = 0; i < 8192; i++) known[i] = 1'b0;

        // R1: reset state
        wt(3);
        chk("R1 sda_oe low in reset", sda_oe, 0);
        wt(7);
        rst = 1'b0;
        wt(20);
        chk("R1 sda_oe low after reset", sda_oe, 0);

        // R5: busy window right after a write, then recovery
        wdat[0] = 8'hA5; wdat[1] = 8'h3C;
        write_txn(13'h1FFE, 2, "R3");
        probe(0, "R5 device address refused during write window");
        wt(WRC + 100);
        probe(1, "R5 device address accepted after write window");

        wdat[0] = 8'h11; wdat[1] = 8'h72; wdat[2] = 8'h05;
        write_txn(13'h0000, 3, "R3");
        wt(WRC + 100);

        // R6 / R8 / R9: read across the top of the array
        random_read(13'h1FFE, 4, "R8 sequential read wrap");
        // R7: current-address read continues at 0x0002
        i2c_start();
        send_byte(devb(1), ack);
        chk("R7 current read ack", ack, 1);
        recv_byte(1'b0, b);
        chk("R7 current-address read data", b, model[13'h0002]);
        i2c_stop();

        // R4: page wrap with junk in the high address bits (R3)
        wdat[0] = 8'h9E; wdat[1] = 8'h9F; wdat[2] = 8'h40; wdat[3] = 8'h41;
        write_txn(13'h0A5E, 4, "R4");
        wt(WRC + 100);
        random_read(13'h0A40, 2, "R4 wrapped bytes at page start");
        random_read(13'h0A5E, 2, "R4 bytes at page end");

        // R2: strap high moves the address
        addr_sel = 1'b1;
        wt(10);
        i2c_start();
        send_byte({7'h50, 1'b0}, ack);
        chk("R2 old address ignored with strap high", ack, 0);
        i2c_stop();
        random_read(13'h0000, 2, "R2 read with strap high");
        addr_sel = 1'b0;
        i2c_start();
        send_byte({7'h54, 1'b0}, ack);
        chk("R2 strap-high address ignored with strap low", ack, 0);
        i2c_stop();

        // R10: write protect
        wp = 1'b1;
        wdat[0] = 8'hFF; wdat[1] = 8'hFF;
        write_txn(13'h0000, 2, "R10");
        probe(1, "R10 no write window under protect");
        random_read(13'h0000, 2, "R10 array unchanged under protect");
        wp = 1'b0;

        // R5: address-only write opens no window
        i2c_start();
        send_byte(devb(0), ack);
        chk("R5 address-only write ack", ack, 1);
        send_addr(13'h0001, "R5");
        i2c_stop();
        probe(1, "R5 no window after address-only write");

        // R11: short glitches on both lines during the device byte
        i2c_start();
        glitch_mode = 1;
        send_byte(devb(0), ack);
        glitch_mode = 0;
        chk("R11 SCL glitch ignored", ack, 1);
        i2c_stop();
        i2c_start();
        glitch_mode = 2;
        send_byte(devb(1), ack);
        glitch_mode = 0;
        chk("R11 SDA glitch ignored", ack, 1);
        recv_byte(1'b0, b);
        i2c_stop();

        // R3: full 32-byte page
        for (int i = 0; i < 32; i++) wdat[i] = 8'($urandom);
        write_txn(13'h0100, 32, "R3 full page");
        wt(WRC + 100);
        random_read(13'h0100, 32, "R3 full page readback");

        // constrained random writes and readbacks
        for (int k = 0; k < 4; k++) begin
            logic [12:0] a;
            int n;
            a = 13'($urandom);
            n = 1 + int'($urandom % 6);
            addr_sel = 1'($urandom);
            for (int i = 0; i < n; i++) wdat[i] = 8'($urandom);
            write_txn(a, n, "R3 random");
            wt(WRC + 100);
            random_read({a[12:5], 5'd0}, 32'(a[4:0]) + 32'(n) > 32 ? 32 : int'(a[4:0]) + n,
                        "R4 random readback");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule